// File: doc/BRIEF.md
# Per-Peripheral Clock Gating Controller

This block sits between the master clock and a bank of peripherals and gives software one clock gate per peripheral. Each gate is opened by writing a one to the matching bit of a set register and closed by writing a one to the matching bit of a clear register. A zero in either write leaves that peripheral alone, so several masters or drivers can change their own peripherals without a read-modify-write sequence. A read-only status register returns the gates that are currently open.

Each gated clock is made by a latch that is transparent while the master clock is low, ANDed with the master clock, so a change of state never cuts a high pulse short. A write commits on a rising edge, and the gated clock follows from the next rising edge on. Closing a gate has no handshake with the peripheral; software is expected to let the peripheral finish first. The number of peripherals is a parameter (32 by default). The register port is a plain address, data and write-strobe port with combinational read data; it has no back-pressure.

Top module: `periph_clk_gate`

## Requirements
- R1: A write to word address 0 (set register) opens the gate of every peripheral whose bit in the write data is 1; bits written as 0 leave their peripherals unchanged.
- R2: A write to word address 1 (clear register) closes the gate of every peripheral whose bit in the write data is 1; bits written as 0 leave their peripherals unchanged.
- R3: Reading word address 2 (status register) returns in bit i the state of gate i (1 = open), and `per_en_o` carries the same vector.
- R4: Bit i of every register belongs to peripheral i: `per_clk_o[i]` pulses high with the master clock from the first rising edge after a write that opens gate i, and stays low from the first rising edge after a write that closes it, always low while the master clock is low.
- R5: After reset every gate is closed, the status reads 0 and no gated clock pulses.
- R6: Status bits at or above the peripheral count read 0, and write data bits at or above it have no effect.
- R7: Reading the set or clear register address returns 0, whatever was written to it.
- R8: Writes to the status address or to any unused address change no gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, gated per peripheral |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Write data, bit i for peripheral i |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| per_clk_o | output | N_PERIPH | One gated clock per peripheral |
| per_en_o | output | N_PERIPH | Gate state vector, 1 = open |

## Verification
The assertions take for granted that `reg_wr` and `reg_addr` are known and settled at every rising edge once reset is released, and that the peripheral count does not exceed the data width. The stimulus keeps to this by driving all register inputs on the falling edge and holding reset low from time zero. The bench runs with a peripheral count below the data width so that the unused upper bits can be written and read back.

// File: rtl/pcg_pkg.sv
`timescale 1ns/1ps
package pcg_pkg;
  // Word addresses of the register port
  localparam int unsigned ADR_SET  = 0;
  localparam int unsigned ADR_CLR  = 1;
  localparam int unsigned ADR_STAT = 2;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_SET  = 2'd1,
    ACC_CLR  = 2'd2,
    ACC_STAT = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/pcg_decode.sv
`timescale 1ns/1ps
module pcg_decode
  import pcg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind
);
  always_comb begin
    if (addr == ADDR_W'(ADR_SET))       kind = ACC_SET;
    else if (addr == ADDR_W'(ADR_CLR))  kind = ACC_CLR;
    else if (addr == ADDR_W'(ADR_STAT)) kind = ACC_STAT;
    else                                kind = ACC_NONE;
  end
endmodule

// File: rtl/pcg_state.sv
`timescale 1ns/1ps
module pcg_state
  import pcg_pkg::*;
#(
  parameter int unsigned N_PERIPH = 32,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  acc_kind_e           kind,
  input  logic [DATA_W-1:0]   wdata,
  output logic [N_PERIPH-1:0] en_q
);
  logic [N_PERIPH-1:0] set_v;
  logic [N_PERIPH-1:0] clr_v;
  logic [N_PERIPH-1:0] en_d;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    if (wr && kind == ACC_SET) set_v = wdata[N_PERIPH-1:0];
    if (wr && kind == ACC_CLR) clr_v = wdata[N_PERIPH-1:0];
    // a clear request overrides a set request on the same bit
    en_d = (en_q | set_v) & ~clr_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  p_reset_off_r5: assert property (@(posedge clk) !rst_n |=> en_q == '0)
    else $error("gates open after reset");

  p_set_opens_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && kind == ACC_SET) |=>
      ((en_q & $past(wdata[N_PERIPH-1:0])) == $past(wdata[N_PERIPH-1:0])))
    else $error("set write left a gate closed");

  p_set_keeps_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && kind == ACC_SET) |=>
      ((en_q & ~$past(wdata[N_PERIPH-1:0])) == ($past(en_q) & ~$past(wdata[N_PERIPH-1:0]))))
    else $error("set write touched a zero bit");

  p_clr_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && kind == ACC_CLR) |=> ((en_q & $past(wdata[N_PERIPH-1:0])) == '0))
    else $error("clear write left a gate open");

  p_clr_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && kind == ACC_CLR) |=>
      ((en_q & ~$past(wdata[N_PERIPH-1:0])) == ($past(en_q) & ~$past(wdata[N_PERIPH-1:0]))))
    else $error("clear write touched a zero bit");

  p_other_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && (kind == ACC_SET || kind == ACC_CLR)) |=> $stable(en_q))
    else $error("gate state changed without a set or clear write");
endmodule

// File: rtl/pcg_clk_gate.sv
`timescale 1ns/1ps
module pcg_clk_gate (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic en_lat;

  // transparent while clk is low, holds during the high phase
  always_latch begin
    if (!clk) en_lat = en;
  end

  assign gclk = clk & en_lat;
endmodule

// File: rtl/periph_clk_gate.sv
`timescale 1ns/1ps
module periph_clk_gate
  import pcg_pkg::*;
#(
  parameter int unsigned N_PERIPH = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic                reg_wr,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic [N_PERIPH-1:0] per_clk_o,
  output logic [N_PERIPH-1:0] per_en_o
);
  localparam int unsigned PAD_W = DATA_W - N_PERIPH;

  acc_kind_e           kind;
  logic [N_PERIPH-1:0] en_q;
  logic [DATA_W-1:0]   stat_word;

  pcg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (reg_addr),
    .kind (kind)
  );

  pcg_state #(.N_PERIPH(N_PERIPH), .DATA_W(DATA_W)) u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .kind  (kind),
    .wdata (reg_wdata),
    .en_q  (en_q)
  );

  generate
    if (PAD_W == 0) begin : g_full
      assign stat_word = en_q;
    end else begin : g_pad
      assign stat_word = {{PAD_W{1'b0}}, en_q};
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    if (kind == ACC_STAT) reg_rdata = stat_word;
  end

  for (genvar i = 0; i < N_PERIPH; i++) begin : g_gate
    pcg_clk_gate u_cg (
      .clk  (clk),
      .en   (en_q[i]),
      .gclk (per_clk_o[i])
    );
  end

  assign per_en_o = en_q;

  p_ctl_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(ADR_SET) || reg_addr == ADDR_W'(ADR_CLR)) |-> reg_rdata == '0)
    else $error("control register read back nonzero");

  p_stat_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata >> N_PERIPH) == '0)
    else $error("status bits above peripheral count set");

  p_stat_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(ADR_STAT)) |-> reg_rdata[N_PERIPH-1:0] == per_en_o)
    else $error("status read differs from enable vector");
endmodule

// File: tb/test_periph_clk_gate.sv
`timescale 1ns/1ps
module test_periph_clk_gate;
  localparam int unsigned NP = 20;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 4;
  localparam logic [DW-1:0] LIVE = (DW'(1) << NP) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic          reg_wr = 1'b0;
  logic [DW-1:0] reg_rdata;
  logic [NP-1:0] per_clk_o;
  logic [NP-1:0] per_en_o;

  int total = 0;
  int bad = 0;

  typedef struct {
    string         req;
    logic [DW-1:0] exp;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  periph_clk_gate #(.N_PERIPH(NP), .DATA_W(DW), .ADDR_W(AW)) i_periph_clk_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .per_clk_o (per_clk_o),
    .per_en_o  (per_en_o)
  );

  // monitor: pops expected read results and compares
  initial begin
    forever begin
      item_t it;
      wait (sb.size() != 0);
      #1;
      it = sb.pop_front();
      total++;
      if (reg_rdata !== it.exp) begin
        bad++;
        $display("FAIL %s: read data actual=%h expected=%h", it.req, reg_rdata, it.exp);
      end
    end
  end

  task automatic wr(input int unsigned a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = AW'(a);
    reg_wdata = d;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int unsigned a, input logic [DW-1:0] e, input string req);
    item_t it;
    @(negedge clk);
    reg_addr = AW'(a);
    it.req = req;
    it.exp = e;
    sb.push_back(it);
    #2;
  endtask

  task automatic chk(input logic [NP-1:0] act, input logic [NP-1:0] e, input string what);
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", what, act, e);
    end
  endtask

  // gated clocks in the high phase follow the gate state, all low in the low phase
  task automatic chk_gates(input logic [NP-1:0] e, input string req);
    @(posedge clk);
    #2;
    chk(per_clk_o, e, {req, " gated clocks high phase"});
    @(negedge clk);
    #1;
    chk(per_clk_o, '0, {req, " gated clocks low phase"});
  endtask

  initial begin
    #800000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5: reset state
    chk(per_en_o, '0, "R5 enable vector during reset");
    rst_n = 1'b1;
    rd(2, '0, "R5 status after reset");
    chk_gates('0, "R5");

    // R1, R4: open gates 0 and 2
    wr(0, 32'h0000_0005);
    chk_gates(20'h00005, "R4 open 0,2");
    rd(2, 32'h0000_0005, "R1 status after set");
    wr(0, 32'h0000_0010);
    rd(2, 32'h0000_0015, "R1 zero bits keep state");
    chk(per_en_o, 20'h00015, "R3 enable vector");

    // R2, R4: close gate 0 at once
    wr(1, 32'h0000_0001);
    chk_gates(20'h00014, "R4 close 0");
    rd(2, 32'h0000_0014, "R2 status after clear");
    wr(1, 32'h0000_0000);
    rd(2, 32'h0000_0014, "R2 zero clear keeps state");

    // R7: control registers read 0
    rd(0, '0, "R7 set register read");
    rd(1, '0, "R7 clear register read");

    // R6: upper bits
    wr(0, 32'hFFFF_FFFF);
    rd(2, LIVE, "R6 upper status bits zero");
    chk(per_en_o, '1, "R3 all enabled");
    chk_gates('1, "R4 all open");
    wr(1, 32'hFFF0_0000);
    rd(2, LIVE, "R6 clear of upper bits ignored");

    // R8: status and unused addresses ignore writes
    wr(2, 32'h0000_0000);
    rd(2, LIVE, "R8 status write ignored");
    wr(3, 32'h0000_0000);
    wr(7, 32'hFFFF_FFFF);
    rd(2, LIVE, "R8 unused address write ignored");
    rd(5, '0, "R8 unused address reads zero");

    // R2: close a pattern, then everything
    wr(1, 32'h000A_AAAA);
    rd(2, 32'h0005_5555, "R2 patterned clear");
    chk_gates(20'h55555, "R4 patterned gates");
    wr(1, 32'hFFFF_FFFF);
    rd(2, '0, "R2 clear all");
    chk_gates('0, "R4 all closed");

    // R5: reset while running
    wr(0, 32'h0000_0300);
    rd(2, 32'h0000_0300, "R1 reopen");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(per_en_o, '0, "R5 asynchronous reset");
    @(negedge clk);
    rst_n = 1'b1;
    rd(2, '0, "R5 status after second reset");
    chk_gates('0, "R5");

    wait (sb.size() == 0);
    #2;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule